// File: doc/BRIEF.md
# Motion and Orientation Threshold Interrupt Generator

This block examines every new three-axis acceleration sample and decides whether to raise an interrupt. Each axis is an 8-bit two's-complement value. Each axis is compared with one programmable 7-bit threshold, which gives a "high" flag and a "low" flag per axis. A configuration byte chooses which of the six flags take part and how they combine. The choices are any flag (wakeup), all flags (free-fall), a change to a new single known direction (orientation movement), or a single known direction held (orientation position).

A qualifying condition can be required to last for a programmable number of consecutive samples before it counts. The interrupt can follow the condition or latch it. A latched interrupt is released by a read strobe on the source byte. The source byte reports the active state and the six direction flags seen when the interrupt was raised. The sample strobe comes from an external rate generator. Any filtering of the samples happens upstream.

Top module: `motion_irq_gen`

## Requirements
- R1: In plain modes (`cfg[6]`=0) the magnitude of each axis is compared with the threshold. The high flag is set when the magnitude is strictly greater. The low flag is set when the magnitude is strictly smaller. The value 80h counts as magnitude 127.
- R2: In orientation modes (`cfg[6]`=1) the high flag means the value is non-negative with magnitude above the threshold. The low flag means the value is negative with magnitude above the threshold.
- R3: Mode `cfg[7:6]`=00 signals a condition when any enabled flag is set. The enables are `cfg[5:0]`, ordered Z-high, Z-low, Y-high, Y-low, X-high, X-low from bit 5 down to bit 0.
- R4: Mode 10 signals a condition only when every enabled flag is set. With no flag enabled it never signals.
- R5: Mode 11 signals while exactly one enabled flag is set (a known direction).
- R6: Mode 01 signals for one sample when exactly one enabled flag is set and the set of enabled flags differs from the previous sample's.
- R7: A condition raises the interrupt only on the sample at which its run of consecutive qualifying samples exceeds `dur`. A `dur` of 0 acts on the first sample. Configuration 95h with threshold 16h and `dur` 3 detects free-fall after four quiet samples.
- R8: With `latch_en`=0 the interrupt takes the recognised result of each sample and holds it until the next sample. A read has no effect.
- R9: With `latch_en`=1 an asserted interrupt, and the flags in the source byte, hold until `src_rd` is pulsed. The pulse clears the interrupt.
- R10: A read in the same cycle as a sample that raises a new event leaves the interrupt asserted.
- R11: Source byte: bit 7 is 0, bit 6 equals the interrupt, and bits 5..0 are the enabled flags in the enable order. After reset everything is 0. Outputs change on the clock edge that takes the sample or the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe: a new sample is on the axis inputs |
| acc_x | input | 8 | X sample, two's complement |
| acc_y | input | 8 | Y sample, two's complement |
| acc_z | input | 8 | Z sample, two's complement |
| cfg | input | 8 | Bit 7 AND/OR, bit 6 orientation, bits 5..0 flag enables |
| thresh | input | 7 | Unsigned magnitude threshold |
| dur | input | 7 | Consecutive samples required beyond the first |
| latch_en | input | 1 | Hold the interrupt until a read |
| src_rd | input | 1 | One-cycle read strobe of the source byte |
| irq | output | 1 | Interrupt level, active high |
| src | output | 8 | Source byte: active flag and six direction flags |

## Verification
The assertions assume that `smp_valid` and `src_rd` are single-cycle strobes. They also assume that the checks on the orientation-position flags apply only while `dur` is 0 and latching is off, and the properties carry those conditions explicitly. The stimulus changes configuration only in cycles with no sample, so every sample sees one stable setting. It sweeps all 256 values of one axis at several thresholds and a value grid over all three axes, and it places reads both alone and alongside qualifying samples.

// File: rtl/motion_irq_pkg.sv
// Shared types for the motion interrupt generator.
package motion_irq_pkg;
    // Combination mode held in the two top configuration bits.
    typedef enum logic [1:0] {
        CMB_ANY   = 2'b00,
        CMB_MOVE  = 2'b01,
        CMB_ALL   = 2'b10,
        CMB_POSN  = 2'b11
    } combine_e;

    localparam int NUM_AXES = 3;
    localparam int FLAG_W   = 2 * NUM_AXES;
endpackage

// File: rtl/motion_axis_cmp.sv
// Compares one two's-complement axis sample against an unsigned threshold.
// Plain mode: magnitude above / below. Orientation mode: above in the positive
// or negative direction. Assumes the most negative code maps to the largest
// magnitude. Purely combinational.
module motion_axis_cmp #(
    parameter int SAMPLE_W = 8
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [SAMPLE_W-2:0] thresh,
    input  logic                signed_mode,
    output logic                flag_hi,
    output logic                flag_lo
);
    localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

    logic [SAMPLE_W-1:0] negated;
    logic [SAMPLE_W-2:0] mag;
    logic                is_neg;
    logic                exceeds;

    // Form the saturated magnitude and the two direction flags.
    always_comb begin
        negated = -sample;
        is_neg  = sample[SAMPLE_W-1];
        if (!is_neg)
            mag = sample[SAMPLE_W-2:0];
        else if (sample == MOST_NEG)
            mag = '1;
        else
            mag = negated[SAMPLE_W-2:0];
        exceeds = (mag > thresh);
        if (signed_mode) begin
            flag_hi = exceeds && !is_neg;
            flag_lo = exceeds && is_neg;
        end else begin
            flag_hi = exceeds;
            flag_lo = (mag < thresh);
        end
    end
endmodule

// File: rtl/motion_dir_eval.sv
// Turns the masked direction flags of a sample into a raw condition according
// to the combination mode. Keeps the previous sample's masked flags for
// movement detection. Assumes smp_valid marks each new sample.
module motion_dir_eval
    import motion_irq_pkg::*;
#(
    parameter int FW = FLAG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  combine_e      mode,
    input  logic [FW-1:0] enables,
    input  logic [FW-1:0] masked,
    output logic          cond
);
    logic [FW-1:0] prev_q;
    logic          known;
    logic          all_set;

    // Remember the masked flags of the last sample.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= '0;
        else if (smp_valid)
            prev_q <= masked;
    end

    // Decide the raw condition for the current sample.
    always_comb begin
        known   = $onehot(masked);
        all_set = (enables != '0) && (masked == enables);
        unique case (mode)
            CMB_ANY:  cond = (masked != '0);
            CMB_ALL:  cond = all_set;
            CMB_POSN: cond = known;
            CMB_MOVE: cond = known && (masked != prev_q);
            default:  cond = 1'b0;
        endcase
    end
endmodule

// File: rtl/motion_qual_latch.sv
// Qualifies the raw condition by a consecutive-sample run length. It then
// drives the interrupt either transparently per sample or latched until a
// read, and holds the reported flags. Assumes single-cycle strobes.
module motion_qual_latch #(
    parameter int FW    = 6,
    parameter int DUR_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic             cond,
    input  logic [FW-1:0]    masked,
    input  logic [DUR_W-1:0] dur,
    input  logic             latch_en,
    input  logic             src_rd,
    output logic             active,
    output logic [FW-1:0]    flags
);
    localparam logic [DUR_W-1:0] RUN_MAX = '1;

    logic [DUR_W-1:0] run_q;
    logic             event_now;
    logic             hold_flags;

    // Recognise an event once the prior run already covers the duration.
    always_comb begin
        event_now  = cond && (run_q >= dur);
        hold_flags = latch_en && active && !src_rd;
    end

    // Count consecutive qualifying samples, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (smp_valid)
            run_q <= !cond ? '0 : ((run_q == RUN_MAX) ? run_q : run_q + 1'b1);
    end

    // Interrupt level: follow, or latch with read-clear (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n)
            active <= 1'b0;
        else if (smp_valid)
            active <= latch_en ? (event_now || (active && !src_rd)) : event_now;
        else if (latch_en && src_rd)
            active <= 1'b0;
    end

    // Reported flags: refreshed per sample unless a latched event is held.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags <= '0;
        else if (smp_valid && !hold_flags)
            flags <= masked;
    end
endmodule

// File: rtl/motion_irq_gen.sv
// Top: three axis comparators, mode evaluation, duration qualification and
// latching. Source byte = {0, active, ZH, ZL, YH, YL, XH, XL}.
module motion_irq_gen
    import motion_irq_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int DUR_W    = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] acc_x,
    input  logic [SAMPLE_W-1:0] acc_y,
    input  logic [SAMPLE_W-1:0] acc_z,
    input  logic [7:0]          cfg,
    input  logic [SAMPLE_W-2:0] thresh,
    input  logic [DUR_W-1:0]    dur,
    input  logic                latch_en,
    input  logic                src_rd,
    output logic                irq,
    output logic [7:0]          src
);
    logic [NUM_AXES-1:0][SAMPLE_W-1:0] axis_val;
    logic [FLAG_W-1:0]                 raw_flags;
    logic [FLAG_W-1:0]                 masked;
    logic [FLAG_W-1:0]                 held_flags;
    logic                              cond;
    logic                              active;
    combine_e                          mode;

    // Gather the axes and decode configuration fields.
    always_comb begin
        axis_val[0] = acc_x;
        axis_val[1] = acc_y;
        axis_val[2] = acc_z;
        mode        = combine_e'(cfg[7:6]);
        masked      = raw_flags & cfg[FLAG_W-1:0];
    end

    for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
        motion_axis_cmp #(.SAMPLE_W(SAMPLE_W)) i_cmp (
            .sample     (axis_val[a]),
            .thresh     (thresh),
            .signed_mode(cfg[6]),
            .flag_hi    (raw_flags[2*a+1]),
            .flag_lo    (raw_flags[2*a])
        );
    end

    motion_dir_eval #(.FW(FLAG_W)) i_eval (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_valid(smp_valid),
        .mode     (mode),
        .enables  (cfg[FLAG_W-1:0]),
        .masked   (masked),
        .cond     (cond)
    );

    motion_qual_latch #(.FW(FLAG_W), .DUR_W(DUR_W)) i_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_valid(smp_valid),
        .cond     (cond),
        .masked   (masked),
        .dur      (dur),
        .latch_en (latch_en),
        .src_rd   (src_rd),
        .active   (active),
        .flags    (held_flags)
    );

    // Drive the outputs.
    always_comb begin
        irq = active;
        src = {1'b0, active, held_flags};
    end
endmodule

// File: rtl/motion_irq_chk.sv
// Port-level properties of motion_irq_gen, bound to every instance.
module motion_irq_chk #(
    parameter int DUR_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_valid,
    input logic [7:0]       cfg,
    input logic [DUR_W-1:0] dur,
    input logic             latch_en,
    input logic             src_rd,
    input logic             irq,
    input logic [7:0]       src
);
    p_spare_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (src[7] == 1'b0));

    p_hold_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid && !src_rd) |=> ($stable(irq) && $stable(src)));

    p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en && irq && !src_rd) |=> irq);

    p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en && src_rd && !smp_valid) |=> !irq);

    p_no_enables_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !latch_en && cfg[5:0] == 6'd0) |=> !irq);

    p_posn_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !latch_en && dur == '0 && cfg[7:6] == 2'b11)
        |=> (irq == $onehot(src[5:0])));
endmodule

bind motion_irq_gen motion_irq_chk #(.DUR_W(DUR_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_valid(smp_valid),
    .cfg      (cfg),
    .dur      (dur),
    .latch_en (latch_en),
    .src_rd   (src_rd),
    .irq      (irq),
    .src      (src)
);

// File: tb/test_motion_irq_gen.sv
module test_motion_irq_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_valid = 1'b0;
    logic [7:0] acc_x = '0, acc_y = '0, acc_z = '0;
    logic [7:0] cfg = '0;
    logic [6:0] thresh = '0;
    logic [6:0] dur = '0;
    logic       latch_en = 1'b0;
    logic       src_rd = 1'b0;
    logic       irq;
    logic [7:0] src;

    int checks = 0;
    int errors = 0;

    // Reference state, derived from the requirements.
    logic [5:0] m_prev = '0;
    int         m_run = 0;
    logic       m_act = 1'b0;
    logic [5:0] m_flags = '0;

    always #2 clk = ~clk;

    motion_irq_gen i_motion_irq_gen (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .acc_x(acc_x), .acc_y(acc_y), .acc_z(acc_z),
        .cfg(cfg), .thresh(thresh), .dur(dur),
        .latch_en(latch_en), .src_rd(src_rd), .irq(irq), .src(src)
    );

    function automatic int mag_of(input int v);
        if (v == -128) return 127;
        return (v < 0) ? -v : v;
    endfunction

    // R1/R2 flag rules: bit 2*axis+1 high, bit 2*axis low.
    function automatic logic [5:0] ref_flags(input int x, input int y, input int z,
                                             input int th, input bit orient);
        int v[3];
        logic [5:0] f;
        v[0] = x; v[1] = y; v[2] = z;
        f = '0;
        for (int a = 0; a < 3; a++) begin
            if (orient) begin
                f[2*a+1] = (v[a] >= 0) && (mag_of(v[a]) > th);
                f[2*a]   = (v[a] < 0) && (mag_of(v[a]) > th);
            end else begin
                f[2*a+1] = mag_of(v[a]) > th;
                f[2*a]   = mag_of(v[a]) < th;
            end
        end
        return f;
    endfunction

    task automatic compare(input string tag);
        logic [7:0] exp_src;
        exp_src = {1'b0, m_act, m_flags};
        checks++;
        if (irq !== m_act || src !== exp_src) begin
            errors++;
            $display("FAIL %s: irq=%0b src=%02h expected irq=%0b src=%02h",
                     tag, irq, src, m_act, exp_src);
        end
    endtask

    // Apply one sample (optionally with a read) and check after the edge.
    task automatic sample(input int x, input int y, input int z, input bit rd,
                          input string tag);
        logic [5:0] mk;
        bit cond, evt, known;
        @(negedge clk);
        acc_x = 8'(x); acc_y = 8'(y); acc_z = 8'(z);
        smp_valid = 1'b1; src_rd = rd;
        mk = ref_flags(x, y, z, int'(thresh), cfg[6]) & cfg[5:0];
        known = ($countones(mk) == 1);
        case (cfg[7:6])
            2'b00: cond = (mk != 0);
            2'b10: cond = (cfg[5:0] != 0) && (mk == cfg[5:0]);
            2'b11: cond = known;
            default: cond = known && (mk != m_prev);
        endcase
        evt = cond && (m_run >= int'(dur));
        m_run = cond ? ((m_run < 127) ? m_run + 1 : 127) : 0;
        m_prev = mk;
        if (!(latch_en && m_act && !rd)) m_flags = mk;
        m_act = latch_en ? (evt || (m_act && !rd)) : evt;
        @(posedge clk);
        #1;
        smp_valid = 1'b0; src_rd = 1'b0;
        compare(tag);
    endtask

    // A cycle with no sample, optionally with a read.
    task automatic idle(input bit rd, input string tag);
        @(negedge clk);
        src_rd = rd;
        if (rd && latch_en) m_act = 1'b0;
        @(posedge clk);
        #1;
        src_rd = 1'b0;
        compare(tag);
    endtask

    task automatic setup(input logic [7:0] c, input int th, input int d, input bit lat);
        @(negedge clk);
        cfg = c; thresh = 7'(th); dur = 7'(d); latch_en = lat;
    endtask

    initial begin
        #(100000 * 4);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int grid[7];
        grid = '{-128, -30, -5, 0, 5, 30, 127};
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        compare("R11 reset state");

        // R1: every X value at several thresholds, all flags reported.
        foreach (grid[k]) begin end
        for (int t = 0; t < 3; t++) begin
            int th;
            th = (t == 0) ? 0 : ((t == 1) ? 22 : 127);
            setup(8'h3F, th, 0, 1'b0);
            for (int v = -128; v < 128; v++) sample(v, 0, -th, 1'b0, "R1 magnitude compare");
        end

        // R2 and R5: orientation position over every X value.
        setup(8'hFF, 20, 0, 1'b0);
        for (int v = -128; v < 128; v++) sample(v, 3, -2, 1'b0, "R2 R5 orientation");

        // R3: any of the high flags over a 3-axis grid.
        setup(8'h2A, 20, 0, 1'b0);
        foreach (grid[i]) foreach (grid[j]) foreach (grid[k])
            sample(grid[i], grid[j], grid[k], 1'b0, "R3 any-flag");
        // R4: all low flags over the same grid, then no enables.
        setup(8'h95, 22, 0, 1'b0);
        foreach (grid[i]) foreach (grid[j]) foreach (grid[k])
            sample(grid[i], grid[j], grid[k], 1'b0, "R4 all-flags");
        setup(8'h80, 22, 0, 1'b0);
        sample(0, 0, 0, 1'b0, "R4 no enables");

        // R6: movement pulses on changes between known directions.
        setup(8'h7F, 20, 0, 1'b0);
        sample(0, 0, 64, 1'b0, "R6 enter ZH");
        sample(0, 0, 64, 1'b0, "R6 same direction");
        sample(0, 0, -64, 1'b0, "R6 to ZL");
        sample(0, 0, 0, 1'b0, "R6 unknown");
        sample(0, 0, -64, 1'b0, "R6 back to ZL");
        sample(64, 64, 0, 1'b0, "R6 two axes");
        sample(-90, 0, 0, 1'b0, "R6 to XL");
        sample(-90, 0, 0, 1'b0, "R6 hold XL");

        // R7: free-fall with a duration of 3.
        setup(8'h95, 8'h16, 3, 1'b0);
        for (int n = 0; n < 6; n++) sample(5, -3, 2, 1'b0, "R7 quiet run");
        sample(60, 0, 0, 1'b0, "R7 run broken");
        for (int n = 0; n < 5; n++) sample(-4, 1, 0, 1'b0, "R7 second run");

        // R8: unlatched level holds between samples and ignores reads.
        setup(8'h2A, 20, 0, 1'b0);
        sample(50, 0, 0, 1'b0, "R8 set");
        idle(1'b1, "R8 read ignored");
        idle(1'b0, "R8 hold");
        sample(0, 0, 0, 1'b0, "R8 follow clear");

        // R9 and R10: latched behaviour.
        setup(8'h2A, 20, 0, 1'b1);
        sample(50, 0, 0, 1'b0, "R9 latch set");
        sample(0, 70, 0, 1'b0, "R9 flags frozen");
        sample(0, 0, 0, 1'b0, "R9 stays set");
        idle(1'b0, "R9 idle hold");
        idle(1'b1, "R9 read clears");
        sample(0, 0, 0, 1'b0, "R9 stays clear");
        sample(0, 0, 90, 1'b0, "R10 new event");
        sample(40, 0, 0, 1'b1, "R10 read with event");
        sample(0, 0, 0, 1'b1, "R9 read with quiet sample");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule